// File: doc/BRIEF.md
# Vertical Sync Norm-Tracking Controller

This block is the field-rate part of a 50/60 Hz video sync processor. It counts lines with a line-rate clock enable and decides, field by field, whether a raw vertical sync pulse is accepted. A field ends when a pulse is accepted or when the line count reaches a time-out. At that point the line counter restarts and a one-line vertical reset pulse is issued.

A four-state machine governs acceptance. A short transitional state follows every field end. Two tracking states accept a pulse only inside a narrow window near the expected field length, for the selected norm (50 Hz or 60 Hz). A search state takes any pulse. A saturating up/down stability counter scores every field. The score selects the tracking state with hysteresis, or drops the controller into search. Forced mode pins the norm to one side. In search, forced mode with horizontal lock also stretches the time-out.

Top module: `vsync_norm_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs become: `state_o` = 3 (search), `stab_cnt` = 0, `norm_60` = 0 (50 Hz) and `vreset` = 0. State codes are 0 = transit, 1 = tracking, 2 = locked tracking and 3 = search.
- R2: In states 1 and 2, a sync pulse sampled on a line enable ends the field when the line count L satisfies 622 < L < 628 (50 Hz) or 522 < L < 528 (60 Hz). The line count then restarts at 0 and the state becomes 0.
- R3: In states 1 and 2, a field with no accepted pulse ends when L reaches 628 (50 Hz) or 528 (60 Hz).
- R4: In state 3, any sync pulse ends the field. Without a pulse, the field ends at L = 722 when forced mode and horizontal lock are both set. Otherwise it ends at L = 628 (50 Hz) or L = 528 (60 Hz).
- R5: In state 0, the next line enable selects the next state and ignores the sync input. The choice is 3 if the score is 0, otherwise 2 if the lock flag is set, otherwise 1. The lock flag is set when the score reaches 15 and cleared when it falls below 8.
- R6: With `force_en` high, `norm_60` follows `force_60` one clock later. Without forcing, `norm_60` changes only at a state-3 field end caused by a pulse: it becomes 1 for a pulse in the 60 Hz window, 0 for a pulse in the 50 Hz window, and otherwise keeps its value.
- R7: At each field end the 4-bit score steps up by one if the field was ended by an in-window, unpenalised pulse. Otherwise it steps down by one. It saturates at 0 and 15.
- R8: In states 1 and 2, an out-of-window pulse does not end the field but arms a penalty. The next in-window pulse still ends the field, but it scores as a down step and clears the penalty.
- R9: `vreset` rises on the clock after a field-ending line enable and falls at the next line enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_en | input | 1 | One-cycle strobe per video line |
| vsync_in | input | 1 | Raw vertical sync, sampled on line enables |
| h_lock | input | 1 | Horizontal loop locked |
| force_en | input | 1 | Forced norm mode |
| force_60 | input | 1 | Forced norm: 1 = 60 Hz, 0 = 50 Hz |
| vreset | output | 1 | Vertical reset, one line wide |
| state_o | output | 2 | Controller state code |
| norm_60 | output | 1 | Selected norm, 1 = 60 Hz |
| stab_cnt | output | 4 | Stability score |

## Verification
The embedded assertions check the following on every cycle:
- the score moves by at most one per step;
- search implies a zero score, and locked tracking implies a score of at least 8;
- the transit state lasts exactly one line;
- the line count never passes the long time-out and sits at zero while `vreset` is high;
- an out-of-window pulse leaves the tracking state untouched;
- forcing propagates to `norm_60`.

Only the bench scenarios can show the field-level behaviour:
- the exact field lengths at each time-out;
- the penalty applied to a good pulse after a bad one;
- hysteresis across a full climb and decay of the score;
- automatic norm selection from the pulse position;
- the pulse ignored during the transit line.

// File: rtl/vsync_pkg.sv
// Package: shared state encoding for the vertical sync norm-tracking controller.
// Assumes: a 2-bit state code is visible at the top-level port unchanged.
package vsync_pkg;
    typedef enum logic [1:0] {
        ST_TRANSIT = 2'd0,
        ST_TRACK   = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_SEARCH  = 2'd3
    } vs_state_e;
endpackage

// File: rtl/vsync_line_ctr.sv
// Module: line counter and vertical reset generator.
// Counts line enables since the last field end; restarts on field_end and
// issues a vertical reset that lasts until the next line enable.
// Assumes: field_end is only meaningful while line_en is high.
module vsync_line_ctr #(
    parameter int LC_W   = 10,
    parameter int TO_MAX = 722
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_en,
    input  logic            field_end,
    output logic [LC_W-1:0] lc,
    output logic            vreset
);
    localparam logic [LC_W-1:0] LC_TOP = '1;
    localparam logic [LC_W-1:0] TO_V   = LC_W'(TO_MAX);

    // Advance or restart the line count on every line enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc     <= '0;
            vreset <= 1'b0;
        end else if (line_en) begin
            vreset <= field_end;
            if (field_end)
                lc <= '0;
            else if (lc != LC_TOP)
                lc <= lc + 1'b1;
        end
    end

    // R9
    vreset_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vreset |-> (lc == '0));

    // R4
    lc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lc <= TO_V);
endmodule

// File: rtl/vsync_stab_ctr.sv
// Module: saturating up/down stability score with lock hysteresis.
// Steps once per field end; the lock flag sets at the maximum score and
// clears when the score drops under the hysteresis threshold.
// Assumes: step_up is only meaningful together with field_end.
module vsync_stab_ctr #(
    parameter int NC_W    = 4,
    parameter int NC_HYST = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_en,
    input  logic            field_end,
    input  logic            step_up,
    output logic [NC_W-1:0] nc,
    output logic            locked
);
    localparam logic [NC_W-1:0] NC_MAX = '1;
    localparam logic [NC_W-1:0] HYST_V = NC_W'(NC_HYST);

    logic [NC_W-1:0] nc_d;
    logic            locked_d;

    // Next score and lock flag for a field end.
    always_comb begin
        nc_d     = nc;
        locked_d = locked;
        if (line_en && field_end) begin
            if (step_up)
                nc_d = (nc == NC_MAX) ? nc : nc + 1'b1;
            else
                nc_d = (nc == '0) ? nc : nc - 1'b1;
            if (nc_d == NC_MAX)
                locked_d = 1'b1;
            else if (nc_d < HYST_V)
                locked_d = 1'b0;
        end
    end

    // Register score and lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nc     <= '0;
            locked <= 1'b0;
        end else begin
            nc     <= nc_d;
            locked <= locked_d;
        end
    end

    logic [NC_W:0] nc_x;
    assign nc_x = {1'b0, nc};

    // R7
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nc_x != $past(nc_x)) |-> ((nc_x == $past(nc_x) + 1'b1) || (nc_x + 1'b1 == $past(nc_x))));

    // R5
    lock_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (nc >= HYST_V));
endmodule

// File: rtl/vsync_fsm.sv
// Module: field acceptance state machine and norm selection.
// Decides per line enable whether the field ends, how it scores, the next
// state, the penalty flag and the selected norm.
// Assumes: lc is the count of line enables since the last field end.
module vsync_fsm
    import vsync_pkg::*;
#(
    parameter int LC_W     = 10,
    parameter int NC_W     = 4,
    parameter int NC_HYST  = 8,
    parameter int WIN50_LO = 622,
    parameter int WIN50_HI = 628,
    parameter int WIN60_LO = 522,
    parameter int WIN60_HI = 528,
    parameter int TO_LOCK  = 722
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_en,
    input  logic            vsync_in,
    input  logic            h_lock,
    input  logic            force_en,
    input  logic            force_60,
    input  logic [LC_W-1:0] lc,
    input  logic [NC_W-1:0] nc,
    input  logic            locked,
    output logic            field_end,
    output logic            step_up,
    output vs_state_e       state,
    output logic            norm_60
);
    localparam logic [LC_W-1:0] LO50 = LC_W'(WIN50_LO);
    localparam logic [LC_W-1:0] HI50 = LC_W'(WIN50_HI);
    localparam logic [LC_W-1:0] LO60 = LC_W'(WIN60_LO);
    localparam logic [LC_W-1:0] HI60 = LC_W'(WIN60_HI);
    localparam logic [LC_W-1:0] TOL  = LC_W'(TO_LOCK);
    localparam logic [NC_W-1:0] HYST_V = NC_W'(NC_HYST);

    vs_state_e state_d;
    logic      bad_q, bad_d, n60_d;
    logic      in50, in60, sel_in, sel_to, search_to;

    // Window and time-out decode for the current line.
    always_comb begin
        in50      = (lc > LO50) && (lc < HI50);
        in60      = (lc > LO60) && (lc < HI60);
        sel_in    = norm_60 ? in60 : in50;
        sel_to    = norm_60 ? (lc == HI60) : (lc == HI50);
        search_to = (force_en && h_lock) ? (lc == TOL) : sel_to;
    end

    // Per-line decision: field end, score direction, next state, penalty, norm.
    always_comb begin
        field_end = 1'b0;
        step_up   = 1'b0;
        state_d   = state;
        bad_d     = bad_q;
        n60_d     = force_en ? force_60 : norm_60;
        if (line_en) begin
            case (state)
                ST_TRANSIT: begin
                    if (nc == '0)   state_d = ST_SEARCH;
                    else if (locked) state_d = ST_LOCKED;
                    else             state_d = ST_TRACK;
                end
                ST_TRACK, ST_LOCKED: begin
                    if (vsync_in && sel_in) begin
                        field_end = 1'b1;
                        step_up   = !bad_q;
                        bad_d     = 1'b0;
                    end else begin
                        if (vsync_in) bad_d = 1'b1;
                        if (sel_to) field_end = 1'b1;
                    end
                end
                default: begin
                    if (!force_en && vsync_in) begin
                        if (in60)      n60_d = 1'b1;
                        else if (in50) n60_d = 1'b0;
                    end
                    if (vsync_in) begin
                        field_end = 1'b1;
                        step_up   = n60_d ? in60 : in50;
                    end else if (search_to) begin
                        field_end = 1'b1;
                    end
                end
            endcase
            if (field_end) state_d = ST_TRANSIT;
        end
    end

    // Register state, penalty flag and norm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_SEARCH;
            bad_q   <= 1'b0;
            norm_60 <= 1'b0;
        end else begin
            state   <= state_d;
            bad_q   <= bad_d;
            norm_60 <= n60_d;
        end
    end

    // R5
    transit_one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRANSIT && line_en) |=> (state != ST_TRANSIT));

    // R5
    search_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH) |-> (nc == '0));

    // R5
    locked_score_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) |-> (nc >= HYST_V));

    // R8
    stray_pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TRACK || state == ST_LOCKED) && line_en && vsync_in && !sel_in && !sel_to)
        |=> (state == $past(state)));
endmodule

// File: rtl/vsync_norm_ctrl.sv
// Module: top of the vertical sync norm-tracking controller.
// Wires the line counter, stability score and acceptance state machine.
// Assumes: line_en is a single-cycle strobe per line; inputs are synchronous.
module vsync_norm_ctrl #(
    parameter int LC_W     = 10,
    parameter int NC_W     = 4,
    parameter int NC_HYST  = 8,
    parameter int WIN50_LO = 622,
    parameter int WIN50_HI = 628,
    parameter int WIN60_LO = 522,
    parameter int WIN60_HI = 528,
    parameter int TO_LOCK  = 722
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_en,
    input  logic            vsync_in,
    input  logic            h_lock,
    input  logic            force_en,
    input  logic            force_60,
    output logic            vreset,
    output logic [1:0]      state_o,
    output logic            norm_60,
    output logic [NC_W-1:0] stab_cnt
);
    import vsync_pkg::*;

    logic [LC_W-1:0] lc;
    logic            field_end, step_up, locked;
    vs_state_e       state;

    vsync_line_ctr #(.LC_W(LC_W), .TO_MAX(TO_LOCK)) i_line (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .field_end(field_end),
        .lc(lc), .vreset(vreset)
    );

    vsync_stab_ctr #(.NC_W(NC_W), .NC_HYST(NC_HYST)) i_stab (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .field_end(field_end),
        .step_up(step_up), .nc(stab_cnt), .locked(locked)
    );

    vsync_fsm #(
        .LC_W(LC_W), .NC_W(NC_W), .NC_HYST(NC_HYST),
        .WIN50_LO(WIN50_LO), .WIN50_HI(WIN50_HI),
        .WIN60_LO(WIN60_LO), .WIN60_HI(WIN60_HI), .TO_LOCK(TO_LOCK)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .vsync_in(vsync_in),
        .h_lock(h_lock), .force_en(force_en), .force_60(force_60),
        .lc(lc), .nc(stab_cnt), .locked(locked),
        .field_end(field_end), .step_up(step_up), .state(state), .norm_60(norm_60)
    );

    assign state_o = state;

    // R6
    force_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_en |=> (norm_60 == $past(force_60)));
endmodule

// File: tb/test_vsync_norm_ctrl.sv
// Bench: behavioural reference model compared every clock, plus scenario checks.
module test_vsync_norm_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_en = 1'b0, vsync_in = 1'b0, h_lock = 1'b0, force_en = 1'b0, force_60 = 1'b0;
    logic vreset, norm_60;
    logic [1:0] state_o;
    logic [3:0] stab_cnt;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    vsync_norm_ctrl i_vsync_norm_ctrl (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .vsync_in(vsync_in),
        .h_lock(h_lock), .force_en(force_en), .force_60(force_60),
        .vreset(vreset), .state_o(state_o), .norm_60(norm_60), .stab_cnt(stab_cnt)
    );

    always #5 clk = ~clk;

    // Reference model state
    int m_st = 3, m_lc = 0, m_nc = 0, m_lock = 0, m_bad = 0, m_n60 = 0, m_vr = 0;
    int t_n60, t_nxt, t_bad, t_fe, t_up, t_i50, t_i60, t_sin, t_sto, t_lim;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 3; m_lc = 0; m_nc = 0; m_lock = 0; m_bad = 0; m_n60 = 0; m_vr = 0;
        end else begin
            t_n60 = force_en ? int'(force_60) : m_n60;
            t_nxt = m_st; t_bad = m_bad; t_fe = 0; t_up = 0;
            if (line_en) begin
                t_i50 = (m_lc > 622 && m_lc < 628);
                t_i60 = (m_lc > 522 && m_lc < 528);
                t_sin = m_n60 ? t_i60 : t_i50;
                t_sto = (m_lc == (m_n60 ? 528 : 628));
                if (m_st == 0) begin
                    t_nxt = (m_nc == 0) ? 3 : (m_lock ? 2 : 1);
                end else if (m_st == 3) begin
                    if (!force_en && vsync_in)
                        t_n60 = t_i60 ? 1 : (t_i50 ? 0 : t_n60);
                    t_lim = (force_en && h_lock) ? 722 : (m_n60 ? 528 : 628);
                    if (vsync_in) begin t_fe = 1; t_up = t_n60 ? t_i60 : t_i50; end
                    else if (m_lc == t_lim) t_fe = 1;
                end else begin
                    if (vsync_in && t_sin) begin t_fe = 1; t_up = !m_bad; t_bad = 0; end
                    else begin
                        if (vsync_in) t_bad = 1;
                        if (t_sto) t_fe = 1;
                    end
                end
                if (t_fe) begin
                    if (t_up) m_nc = (m_nc < 15) ? m_nc + 1 : 15;
                    else      m_nc = (m_nc > 0) ? m_nc - 1 : 0;
                    if (m_nc == 15) m_lock = 1;
                    else if (m_nc < 8) m_lock = 0;
                    t_nxt = 0;
                end
                m_lc = t_fe ? 0 : m_lc + 1;
                m_vr = t_fe;
            end
            m_st = t_nxt; m_bad = t_bad; m_n60 = t_n60;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Compare against the model every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2/R5 state", int'(state_o), m_st);
            check("R7 score", int'(stab_cnt), m_nc);
            check("R6 norm", int'(norm_60), m_n60);
            check("R9 vreset", int'(vreset), m_vr);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // One line with no pulse (the transit line).
    task automatic one_line();
        @(negedge clk);
        line_en = 1'b1; vsync_in = 1'b0;
        @(negedge clk);
        line_en = 1'b0;
    endtask

    // Run a field from line index start; pulses at lines vs1/vs2; returns lines issued.
    task automatic field(input int start, input int vs1, input int vs2, output int nlines);
        int i = start;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            line_en  = ((k % 7) != 3);
            vsync_in = line_en && (i == vs1 || i == vs2);
            @(posedge clk); #1;
            if (line_en) i++;
            if (vreset) break;
        end
        @(negedge clk);
        line_en = 1'b0; vsync_in = 1'b0;
        nlines = i;
    endtask

    int n;
    initial begin
        repeat (4) @(negedge clk);
        check("R1 state", int'(state_o), 3);
        check("R1 score", int'(stab_cnt), 0);
        check("R1 norm", int'(norm_60), 0);
        check("R1 vreset", int'(vreset), 0);
        rst_n = 1'b1;

        field(0, 625, -1, n);                       // search, 50 Hz pulse
        check("R4 search pulse length", n, 626);
        check("R7 first up", int'(stab_cnt), 1);
        check("R2 transit", int'(state_o), 0);
        for (int f = 0; f < 14; f++) field(0, 625, -1, n);
        check("R7 climb", int'(stab_cnt), 15);
        field(0, 625, -1, n);
        check("R7 saturate high", int'(stab_cnt), 15);
        one_line();
        check("R5 locked entry", int'(state_o), 2);
        field(1, 300, 625, n);
        check("R8 penalised", int'(stab_cnt), 14);
        check("R8 bad pulse kept field", n, 626);
        field(0, 600, -1, n);
        check("R3 time-out 50", n, 629);
        field(0, 625, -1, n);
        check("R8 penalty after stray", int'(stab_cnt), 12);
        for (int f = 0; f < 5; f++) field(0, -1, -1, n);
        check("R7 decay", int'(stab_cnt), 7);
        one_line();
        check("R5 hysteresis exit", int'(state_o), 1);
        field(1, -1, -1, n);
        for (int f = 0; f < 6; f++) field(0, -1, -1, n);
        check("R7 floor", int'(stab_cnt), 0);
        one_line();
        check("R5 search entry", int'(state_o), 3);
        field(1, 525, -1, n);
        check("R6 auto 60", int'(norm_60), 1);
        field(0, -1, -1, n);
        check("R3 time-out 60", n, 529);
        field(0, -1, -1, n);
        check("R4 unlocked 60 time-out", n, 529);
        check("R7 saturate low", int'(stab_cnt), 0);

        @(negedge clk); force_en = 1'b1; force_60 = 1'b0; h_lock = 1'b1;
        field(0, -1, -1, n);
        check("R4 long time-out", n, 723);
        check("R6 forced 50", int'(norm_60), 0);
        @(negedge clk); h_lock = 1'b0;
        field(0, -1, -1, n);
        check("R4 forced unlocked time-out", n, 629);
        field(0, 525, -1, n);
        check("R4 any pulse ends search", n, 526);
        check("R6 forced norm kept", int'(norm_60), 0);
        @(negedge clk); force_60 = 1'b1;
        field(0, 525, -1, n);
        check("R7 forced 60 up", int'(stab_cnt), 1);
        field(0, 0, -1, n);
        check("R5 transit pulse ignored", n, 529);
        @(negedge clk); force_en = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule